// File: doc/BRIEF.md
# Semaphore-Driven Descriptor Channel Controller

This block is the command front end of a memory-to-memory processing engine. Software prepares chains of eight-word descriptors in memory. For each channel it writes the address of the first descriptor into a command pointer register. It then bumps a per-channel counting semaphore through a 32-bit register port. A channel that is enabled, has a live pointer and holds a non-zero semaphore is picked by a fixed-priority arbiter. Its descriptor is read one word at a time over a shared memory read port, and the decoded fields are handed to a processing unit through a start/done/error handshake.

When the processing unit finishes, the descriptor's own flag bits decide two things: whether the channel semaphore counts down, and whether the channel's bit in the global interrupt status is set. The controller then moves on to the descriptor named by the next pointer, or ends the chain when that pointer is zero. A failed memory read or a unit error records an error code in the channel status, stops the chain, leaves the semaphore alone and raises the interrupt bit. Both status registers have write-one-to-clear aliases.

Top module: `dchan_ctrl`

## Requirements
- R1: After reset the global status, the channel enables, the context register and every channel pointer, semaphore and status read as zero, `irq` is low and `mem_req` is low.
- R2: A write to a channel semaphore register (0x110 + n*0x40) with data bit 0 set raises its count by one. A write with bit 0 clear has no effect, and the count holds at 255 once it gets there.
- R3: A selected channel reads eight words at its pointer P, at addresses P, P+4, …, P+28. Word 0 is the next pointer, word 1 the control word the flags sit in, word 2 the second control word, word 3 the source, word 4 the destination, word 5 the byte count, word 6 the payload address and word 7 the status slot. Words 1 to 6 then appear on the `eng_*` outputs together with a one-cycle `eng_start` and the channel number.
- R4: Bit n of the enable register at 0x20 gates channel n. A channel whose bit is clear never starts a fetch, and its semaphore keeps its value.
- R5: On successful completion, control word bit 1 set makes the channel semaphore count down by one. Control word bit 0 set makes the channel's global status bit go high, which drives `irq`.
- R6: The global status at 0x10 shows one bit per channel in bits 3:0, and `irq` is their OR. Writing ones to 0x18 clears the matching bits.
- R7: A non-zero next pointer is loaded into the channel pointer and fetched while the semaphore is non-zero. A zero next pointer ends the chain, and no further fetch happens on that channel until its pointer is written again, even with a non-zero semaphore.
- R8: When several channels are eligible in the same cycle, the lowest-numbered one is served first, and one descriptor at a time runs.
- R9: A memory read error during a fetch sets channel status code 0x01, and a unit error sets code 0x02. Either one ends the chain without a semaphore count-down and sets the channel's global status bit.
- R10: Writing ones to a channel status clear alias (0x128 + n*0x40) clears the matching status bits.
- R11: The context register at 0x50 reads back what was written. The capability register at 0x40 returns the build-time value, with bit 0 for the 128-bit cipher and bits 16 and 18 for the two hash engines, and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Memory byte address of the word being fetched |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_err | input | 1 | Memory read error, valid with `mem_ack` |
| eng_start | output | 1 | One-cycle start pulse to the processing unit |
| eng_chan | output | CW | Channel that owns the current descriptor |
| eng_ctrl0 | output | 32 | Descriptor control word with the flags |
| eng_ctrl1 | output | 32 | Descriptor second control word |
| eng_src | output | 32 | Descriptor source address |
| eng_dst | output | 32 | Descriptor destination address |
| eng_size | output | 32 | Descriptor byte count |
| eng_payload | output | 32 | Descriptor payload address |
| eng_done | input | 1 | Processing unit finished |
| eng_err | input | 1 | Processing unit failed, valid with `eng_done` |
| irq | output | 1 | OR of the global status bits |

## Verification
Several rules are checked by assertions on every cycle. A fetch request holds its address until it is acknowledged. No fetch starts on a disabled channel, and none passes over a lower-numbered eligible channel. A flagged completion sets the interrupt bit on the next cycle, a saturated semaphore stays at its ceiling, and a failure always leaves a non-zero code. Other behaviour shows only over whole scenarios, so the bench runs each of them:
- each descriptor's fields reach the unit in order;
- a chain is followed and ends on a zero pointer;
- the semaphore does or does not count down according to the descriptor's flag;
- a disabled channel keeps its work pending;
- error recovery through the clear aliases.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
   // global register byte offsets
   localparam logic [11:0] A_GSTAT     = 12'h010;
   localparam logic [11:0] A_GSTAT_CLR = 12'h018;
   localparam logic [11:0] A_CHEN      = 12'h020;
   localparam logic [11:0] A_CAP       = 12'h040;
   localparam logic [11:0] A_CTX       = 12'h050;
   localparam logic [11:0] A_CH_BASE   = 12'h100;
   localparam int unsigned CH_STRIDE   = 64;

   // offsets inside one channel window
   localparam logic [5:0] O_PTR      = 6'h00;
   localparam logic [5:0] O_SEMA     = 6'h10;
   localparam logic [5:0] O_STAT     = 6'h20;
   localparam logic [5:0] O_STAT_CLR = 6'h28;

   // descriptor word slots
   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned W_NEXT  = 0;
   localparam int unsigned W_CTRL0 = 1;
   localparam int unsigned W_CTRL1 = 2;
   localparam int unsigned W_SRC   = 3;
   localparam int unsigned W_DST   = 4;
   localparam int unsigned W_SIZE  = 5;
   localparam int unsigned W_PAY   = 6;

   // control word flag positions
   localparam int unsigned C0_IRQ = 0;
   localparam int unsigned C0_DEC = 1;

   localparam logic [7:0] ERR_MEM = 8'h01;
   localparam logic [7:0] ERR_ENG = 8'h02;

   typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_KICK, SQ_WAIT} seq_t;

   function automatic logic [11:0] ch_reg(int unsigned ch, logic [5:0] ofs);
      return A_CH_BASE + 12'(ch * CH_STRIDE) + {6'b0, ofs};
   endfunction
endpackage

// File: rtl/dchan_arb.sv
module dchan_arb #(
   parameter int unsigned N          = 4,
   parameter bit          HIGH_FIRST = 1'b0,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   if (N < 1) begin : g_bad_n
      $error("dchan_arb: N must be at least 1");
   end

   if (HIGH_FIRST) begin : g_high
      always_comb begin
         gnt_idx = '0;
         any     = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) begin
               gnt_idx = IW'(i);
               any     = 1'b1;
            end
         end
      end
   end else begin : g_low
      always_comb begin
         gnt_idx = '0;
         any     = 1'b0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               gnt_idx = IW'(i);
               any     = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dchan_fetch.sv
module dchan_fetch #(
   parameter int unsigned AW   = 32,
   parameter int unsigned NW   = 8,
   parameter int unsigned KEEP = 7,
   localparam int unsigned IW  = $clog2(NW)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [AW-1:0]         base,
   output logic                  mem_req,
   output logic [AW-1:0]         mem_addr,
   input  logic                  mem_ack,
   input  logic [31:0]           mem_rdata,
   input  logic                  mem_err,
   output logic [KEEP-1:0][31:0] words,
   output logic                  done,
   output logic                  fail
);
   if (NW < 2 || KEEP > NW) begin : g_bad_cfg
      $error("dchan_fetch: need NW >= 2 and KEEP <= NW");
   end

   logic          busy;
   logic [IW-1:0] idx;
   logic [AW-1:0] base_q;

   assign mem_req  = busy;
   assign mem_addr = base_q + (AW'(idx) << 2);
   assign done     = busy && mem_ack && !mem_err && (idx == IW'(NW - 1));
   assign fail     = busy && mem_ack && mem_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         base_q <= '0;
         words  <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         idx    <= '0;
         base_q <= base;
      end else if (busy && mem_ack) begin
         if (mem_err) begin
            busy <= 1'b0;
         end else begin
            if (int'(idx) < KEEP) words[idx] <= mem_rdata;
            if (idx == IW'(NW - 1)) busy <= 1'b0;
            else idx <= idx + 1'b1;
         end
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/dchan_chan.sv
module dchan_chan #(
   parameter int unsigned AW     = 32,
   parameter int unsigned SEMA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ptr,
   input  logic [AW-1:0]     ptr_wdata,
   input  logic              wr_inc,
   input  logic [7:0]        clr_mask,
   input  logic              done_ok,
   input  logic              done_dec,
   input  logic [AW-1:0]     next_ptr,
   input  logic              fail,
   input  logic [7:0]        fail_code,
   output logic [AW-1:0]     ptr,
   output logic [SEMA_W-1:0] sema,
   output logic [7:0]        err,
   output logic              ready
);
   localparam logic [SEMA_W-1:0] SEMA_MAX = {SEMA_W{1'b1}};

   logic armed;
   logic inc, dec;

   assign inc   = wr_inc && (sema != SEMA_MAX);
   assign dec   = done_dec && (sema != '0);
   assign ready = armed && (sema != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         sema  <= '0;
         err   <= '0;
         armed <= 1'b0;
      end else begin
         if (wr_ptr) begin
            ptr   <= ptr_wdata;
            armed <= 1'b1;
         end else if (fail) begin
            armed <= 1'b0;
         end else if (done_ok) begin
            if (next_ptr != '0) ptr <= next_ptr;
            else armed <= 1'b0;
         end

         case ({inc, dec})
            2'b10:   sema <= sema + 1'b1;
            2'b01:   sema <= sema - 1'b1;
            default: sema <= sema;
         endcase

         err <= (err & ~clr_mask) | (fail ? fail_code : 8'h00);
      end
   end

   // R2
   sema_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sema == SEMA_MAX && wr_inc && !done_dec) |=> (sema == SEMA_MAX));

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> (err != 8'h00));
endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
   import dchan_pkg::*;
#(
   parameter int unsigned NCH       = 4,
   parameter int unsigned AW        = 32,
   parameter int unsigned SEMA_W    = 8,
   parameter logic [31:0] CAP_VALUE = 32'h0005_0001,
   localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [11:0]   reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_err,
   output logic          eng_start,
   output logic [CW-1:0] eng_chan,
   output logic [31:0]   eng_ctrl0,
   output logic [31:0]   eng_ctrl1,
   output logic [31:0]   eng_src,
   output logic [31:0]   eng_dst,
   output logic [31:0]   eng_size,
   output logic [31:0]   eng_payload,
   input  logic          eng_done,
   input  logic          eng_err,
   output logic          irq
);
   localparam int unsigned KEEP = W_PAY + 1;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("dchan_ctrl: NCH must be 1..4");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("dchan_ctrl: AW must be 8..32");
   end
   if (SEMA_W < 1 || SEMA_W > 8) begin : g_bad_sema
      $error("dchan_ctrl: SEMA_W must be 1..8");
   end

   seq_t                        state;
   logic [CW-1:0]               cur_ch;
   logic [7:0]                  chan_en;
   logic [31:0]                 ctx_q;
   logic [NCH-1:0]              gstat;

   logic [NCH-1:0]              ready_v, avail, ok_v, fail_v, set_v;
   logic [NCH-1:0][AW-1:0]      ptr_v;
   logic [NCH-1:0][SEMA_W-1:0]  sema_v;
   logic [NCH-1:0][7:0]         err_v;
   logic [CW-1:0]               gnt_idx;
   logic                        gnt_any, fetch_start;
   logic [KEEP-1:0][31:0]       f_words;
   logic                        f_done, f_fail;
   logic                        fin_any, mem_bad;
   logic [7:0]                  code;
   logic [AW-1:0]               next_ptr;

   assign avail       = ready_v & chan_en[NCH-1:0];
   assign fetch_start = (state == SQ_IDLE) && gnt_any;
   assign fin_any     = (state == SQ_WAIT) && eng_done;
   assign mem_bad     = (state == SQ_FETCH) && f_fail;
   assign code        = mem_bad ? ERR_MEM : ERR_ENG;
   assign next_ptr    = f_words[W_NEXT][AW-1:0];

   dchan_arb #(.N(NCH), .HIGH_FIRST(1'b0)) u_arb (
      .req(avail), .gnt_idx(gnt_idx), .any(gnt_any)
   );

   dchan_fetch #(.AW(AW), .NW(DESC_WORDS), .KEEP(KEEP)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(fetch_start), .base(ptr_v[gnt_idx]),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .words(f_words), .done(f_done), .fail(f_fail)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic sel;
      assign sel       = (cur_ch == CW'(g));
      assign ok_v[g]   = sel && fin_any && !eng_err;
      assign fail_v[g] = sel && (mem_bad || (fin_any && eng_err));
      assign set_v[g]  = fail_v[g] || (ok_v[g] && eng_ctrl0[C0_IRQ]);

      dchan_chan #(.AW(AW), .SEMA_W(SEMA_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr_ptr(reg_wr && reg_addr == ch_reg(g, O_PTR)),
         .ptr_wdata(reg_wdata[AW-1:0]),
         .wr_inc(reg_wr && reg_addr == ch_reg(g, O_SEMA) && reg_wdata[0]),
         .clr_mask((reg_wr && reg_addr == ch_reg(g, O_STAT_CLR)) ? reg_wdata[7:0] : 8'h00),
         .done_ok(ok_v[g]),
         .done_dec(ok_v[g] && eng_ctrl0[C0_DEC]),
         .next_ptr(next_ptr),
         .fail(fail_v[g]), .fail_code(code),
         .ptr(ptr_v[g]), .sema(sema_v[g]), .err(err_v[g]), .ready(ready_v[g])
      );
   end

   // sequencer: one descriptor at a time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cur_ch <= '0;
      end else begin
         case (state)
            SQ_IDLE:  if (gnt_any) begin
                         cur_ch <= gnt_idx;
                         state  <= SQ_FETCH;
                      end
            SQ_FETCH: if (f_fail) state <= SQ_IDLE;
                      else if (f_done) state <= SQ_KICK;
            SQ_KICK:  state <= SQ_WAIT;
            SQ_WAIT:  if (eng_done) state <= SQ_IDLE;
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   // global registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en <= '0;
         ctx_q   <= '0;
         gstat   <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CHEN) chan_en <= reg_wdata[7:0];
         if (reg_wr && reg_addr == A_CTX)  ctx_q   <= reg_wdata;
         gstat <= (gstat & ~((reg_wr && reg_addr == A_GSTAT_CLR) ? reg_wdata[NCH-1:0] : '0))
                  | set_v;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_GSTAT: reg_rdata[NCH-1:0] = gstat;
         A_CHEN:  reg_rdata[7:0]     = chan_en;
         A_CAP:   reg_rdata          = CAP_VALUE;
         A_CTX:   reg_rdata          = ctx_q;
         default: reg_rdata          = '0;
      endcase
      for (int i = 0; i < NCH; i++) begin
         if (reg_addr == ch_reg(i, O_PTR))  reg_rdata = 32'(ptr_v[i]);
         if (reg_addr == ch_reg(i, O_SEMA)) reg_rdata = 32'(sema_v[i]);
         if (reg_addr == ch_reg(i, O_STAT)) reg_rdata = 32'(err_v[i]);
      end
   end

   assign eng_start   = (state == SQ_KICK);
   assign eng_chan    = cur_ch;
   assign eng_ctrl0   = f_words[W_CTRL0];
   assign eng_ctrl1   = f_words[W_CTRL1];
   assign eng_src     = f_words[W_SRC];
   assign eng_dst     = f_words[W_DST];
   assign eng_size    = f_words[W_SIZE];
   assign eng_payload = f_words[W_PAY];
   assign irq         = |gstat;

   // R4
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |-> chan_en[gnt_idx]);

   // R8
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |-> ((avail & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0));

   // R5
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_any && !eng_err && eng_ctrl0[C0_IRQ]) |=> gstat[cur_ch]);

   // R8
   single_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !mem_req);
endmodule

// File: tb/dchan_ctrl_test.sv
`timescale 1ns/1ps
module dchan_ctrl_test;
   localparam logic [31:0] CAP = 32'h0005_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;
   logic        eng_start;
   logic [1:0]  eng_chan;
   logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size, eng_payload;
   logic        eng_done = 1'b0;
   logic        eng_err = 1'b0;
   logic        irq;

   dchan_ctrl #(.CAP_VALUE(CAP)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .eng_start(eng_start), .eng_chan(eng_chan), .eng_ctrl0(eng_ctrl0),
      .eng_ctrl1(eng_ctrl1), .eng_src(eng_src), .eng_dst(eng_dst),
      .eng_size(eng_size), .eng_payload(eng_payload),
      .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic [31:0] ch, c0, c1, src, dst, size, pay;
   } item_t;

   item_t       expq[$];
   int          ch_log[$];
   logic [31:0] mem [0:511];
   logic [31:0] err_addr = 32'hFFFF_FFFF;
   logic        inj_eng = 1'b0;
   int          checks = 0;
   int          errors = 0;
   int          starts = 0;
   int          eng_cnt = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] chr(int ch, int ofs);
      return 12'(32'h100 + ch * 64 + ofs);
   endfunction

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(int a, logic [31:0] nxt, logic [31:0] c0, logic [31:0] tag);
      mem[a/4 + 0] = nxt;
      mem[a/4 + 1] = c0;
      mem[a/4 + 2] = tag ^ 32'h0000_0010;
      mem[a/4 + 3] = tag ^ 32'h1000_0000;
      mem[a/4 + 4] = tag ^ 32'h2000_0000;
      mem[a/4 + 5] = tag & 32'h0000_0FFF;
      mem[a/4 + 6] = tag ^ 32'h3000_0000;
      mem[a/4 + 7] = 32'h0;
   endtask

   // driver side of the scoreboard: expected hand-off for a descriptor
   task automatic expect_desc(int ch, int a);
      item_t it;
      it.ch = ch; it.c0 = mem[a/4+1]; it.c1 = mem[a/4+2]; it.src = mem[a/4+3];
      it.dst = mem[a/4+4]; it.size = mem[a/4+5]; it.pay = mem[a/4+6];
      expq.push_back(it);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // memory model
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[10:2]];
            mem_err   = (mem_addr == err_addr);
         end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
         end
      end
   end

   // processing unit stub and scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         eng_done = 1'b0;
         eng_err  = 1'b0;
         if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
               eng_done = 1'b1;
               eng_err  = inj_eng;
            end
         end
         if (eng_start) begin
            item_t e;
            starts++;
            ch_log.push_back(int'(eng_chan));
            eng_cnt = 3;
            if (expq.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3 actual start on ch %0d expected none", eng_chan);
            end else begin
               e = expq.pop_front();
               chk("R3 chan", 32'(eng_chan), e.ch);
               chk("R3 ctrl0", eng_ctrl0, e.c0);
               chk("R3 ctrl1", eng_ctrl1, e.c1);
               chk("R3 src", eng_src, e.src);
               chk("R3 dst", eng_dst, e.dst);
               chk("R3 size", eng_size, e.size);
               chk("R3 payload", eng_payload, e.pay);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int s0;
      for (int i = 0; i < 512; i++) mem[i] = 32'h0;
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'h010, v); chk("R1 gstat", v, 0);
      rd(12'h020, v); chk("R1 enables", v, 0);
      rd(12'h050, v); chk("R1 ctx", v, 0);
      rd(chr(0, 'h10), v); chk("R1 sema", v, 0);
      rd(chr(3, 'h00), v); chk("R1 ptr", v, 0);
      rd(chr(2, 'h20), v); chk("R1 chstat", v, 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 mem_req", 32'(mem_req), 0);

      // R11 context and capability
      wr(12'h050, 32'hFFFF_0000);
      rd(12'h050, v); chk("R11 ctx", v, 32'hFFFF_0000);
      wr(12'h040, 32'h0);
      rd(12'h040, v); chk("R11 cap", v, CAP);

      // R5 R6 single descriptor, decrement and interrupt
      put_desc('h040, 0, 32'h3, 32'hA000_0040);
      wr(12'h020, 32'h1);
      wr(chr(0, 0), 32'h040);
      expect_desc(0, 'h040);
      wr(chr(0, 'h10), 32'h1);
      idle(60);
      rd(chr(0, 'h10), v); chk("R5 sema decremented", v, 0);
      rd(12'h010, v); chk("R5 gstat bit0", v, 32'h1);
      chk("R6 irq high", 32'(irq), 1);
      wr(12'h018, 32'h1);
      rd(12'h010, v); chk("R6 gstat cleared", v, 0);
      chk("R6 irq low", 32'(irq), 0);

      // R4 disabled channel holds its work; R2 increment
      put_desc('h080, 0, 32'h2, 32'hB000_0080);
      wr(chr(1, 0), 32'h080);
      s0 = starts;
      wr(chr(1, 'h10), 32'h1);
      idle(40);
      chk("R4 no start", 32'(starts - s0), 0);
      rd(chr(1, 'h10), v); chk("R2 R4 sema kept", v, 1);
      expect_desc(1, 'h080);
      wr(12'h020, 32'h2);
      idle(60);
      chk("R4 start after enable", 32'(starts - s0), 1);
      rd(chr(1, 'h10), v); chk("R5 sema after enable", v, 0);
      rd(12'h010, v); chk("R5 no irq flag", v, 0);

      // R7 chain of two, then a zero next pointer with semaphore left
      put_desc('h0C0, 32'h100, 32'h1, 32'hC000_00C0);
      put_desc('h100, 32'h0,   32'h3, 32'hD000_0100);
      wr(12'h020, 32'h4);
      wr(chr(2, 0), 32'h0C0);
      expect_desc(2, 'h0C0);
      expect_desc(2, 'h100);
      s0 = starts;
      wr(chr(2, 'h10), 32'h1);
      idle(100);
      chk("R7 chain starts", 32'(starts - s0), 2);
      rd(chr(2, 'h10), v); chk("R7 sema", v, 0);
      rd(chr(2, 0), v); chk("R7 ptr followed", v, 32'h100);
      rd(12'h010, v); chk("R5 gstat bit2", v, 32'h4);
      wr(12'h018, 32'hF);

      put_desc('h140, 0, 32'h1, 32'hE000_0140);
      wr(12'h020, 32'h8);
      wr(chr(3, 0), 32'h140);
      expect_desc(3, 'h140);
      s0 = starts;
      wr(chr(3, 'h10), 32'h1);
      idle(100);
      chk("R7 chain end no refetch", 32'(starts - s0), 1);
      rd(chr(3, 'h10), v); chk("R5 no decrement", v, 1);
      wr(12'h018, 32'hF);

      // R2 bit0 clear ignored, saturation
      wr(12'h020, 32'h0);
      wr(chr(3, 'h10), 32'h0);
      rd(chr(3, 'h10), v); chk("R2 bit0 clear ignored", v, 1);
      for (int i = 0; i < 300; i++) wr(chr(3, 'h10), 32'h1);
      rd(chr(3, 'h10), v); chk("R2 saturate", v, 255);

      // R8 priority: two channels become eligible together
      put_desc('h180, 0, 32'h2, 32'hF000_0180);
      put_desc('h1C0, 0, 32'h2, 32'h9000_01C0);
      wr(chr(1, 0), 32'h1C0);
      wr(chr(0, 0), 32'h180);
      wr(chr(1, 'h10), 32'h1);
      wr(chr(0, 'h10), 32'h1);
      expect_desc(0, 'h180);
      expect_desc(1, 'h1C0);
      ch_log.delete();
      wr(12'h020, 32'h3);
      idle(100);
      chk("R8 count", 32'(ch_log.size()), 2);
      if (ch_log.size() == 2) begin
         chk("R8 first", 32'(ch_log[0]), 0);
         chk("R8 second", 32'(ch_log[1]), 1);
      end

      // R9 memory error, R10 clear
      wr(12'h020, 32'h1);
      put_desc('h200, 0, 32'h3, 32'h8000_0200);
      err_addr = 32'h208;
      wr(chr(0, 0), 32'h200);
      s0 = starts;
      wr(chr(0, 'h10), 32'h1);
      idle(60);
      err_addr = 32'hFFFF_FFFF;
      chk("R9 no start", 32'(starts - s0), 0);
      rd(chr(0, 'h20), v); chk("R9 mem code", v, 32'h01);
      rd(chr(0, 'h10), v); chk("R9 sema kept", v, 1);
      rd(12'h010, v); chk("R9 gstat bit0", v, 32'h1);
      wr(chr(0, 'h28), 32'hFF);
      rd(chr(0, 'h20), v); chk("R10 chstat cleared", v, 0);
      idle(30);
      chk("R9 chain stopped", 32'(starts - s0), 0);
      wr(12'h018, 32'hF);

      // R9 unit error
      wr(12'h020, 32'h2);
      put_desc('h240, 0, 32'h3, 32'h7000_0240);
      wr(chr(1, 0), 32'h240);
      expect_desc(1, 'h240);
      inj_eng = 1'b1;
      wr(chr(1, 'h10), 32'h1);
      idle(60);
      inj_eng = 1'b0;
      rd(chr(1, 'h20), v); chk("R9 unit code", v, 32'h02);
      rd(chr(1, 'h10), v); chk("R9 unit sema kept", v, 1);
      rd(12'h010, v); chk("R9 gstat bit1", v, 32'h2);
      chk("R3 queue drained", 32'(expq.size()), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule